// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Multiplexer

This block holds the digital dividers that surround a frequency-synthesizer loop. The phase detector and the oscillator are outside it. A reference clock is picked from a crystal clock or an external reference clock. It passes through a fixed divide-by-16 prescaler and leaves on `refClk` for the phase detector. The oscillator clock is divided by a programmable M and then halved by a toggle stage, and the result leaves on `fbClk` as the feedback clock. When the loop is locked, the oscillator therefore runs at 2·M times the prescaled reference.

The oscillator clock also drives a programmable output divider. Its 2-bit code is deliberately non-monotonic: 00 gives /2, 01 gives /4, 10 gives /8 and 11 gives /1. Every setting has a 50% duty cycle. An output enable gates the complementary output pair. A 3-bit test code selects one of eight internal nodes for a single test pin. One of these nodes is a second M divider that counts the serial configuration clock.

The whole block runs on the oscillator clock, `clkVco`. The crystal, external-reference and serial clocks are slow compared with it, so they are oversampled through synchronizers and their rising edges are counted. Only the /1 output setting passes `clkVco` straight through.

Top module: `synth_div_top`

## Requirements
- R1: While `rstN` is low, `refClk`, `fbClk`, `testOut` (with test code 010) and `outClk` are low, and `outClkN` is high.
- R2: With `refSel` high the crystal clock is the reference; with `refSel` low the external clock is. After a two-stage synchronizer and a rising-edge detector, `refClk` toggles on every 8th detected reference edge, which divides the reference by 16.
- R3: `fbClk` toggles once every M `clkVco` cycles, so its period is 2·M cycles. An M of 0 behaves as 1.
- R4: A new `mVal` is taken only when the M count wraps. The count in progress always completes with the old value.
- R5: Output code 00 divides by 2, 01 by 4, 10 by 8 and 11 passes `clkVco` through (/1). Every setting has equal high and low phases.
- R6: A new `nCode` is applied only at the end of a low phase of the output. The new setting starts with a full high phase, so no runt pulse appears.
- R7: The `tSel` codes are: 000 gives `scanIn`, 001 gives constant 1, 010 gives the prescaled reference, 011 gives the feedback clock, 100 gives the ungated main output, 101 gives constant 0, 110 gives the serial M divider, and 111 gives the main output divided by 4.
- R8: When `outEn` is low, `outClk` is held at 0 and `outClkN` at 1. When `outEn` is high, `outClkN` is always the complement of `outClk`.
- R9: The serial M divider counts rising edges of `serClk` after the same two-stage synchronizer. It follows R3 and R4 in units of those edges, and its toggle output appears on `tSel` 110.
- R10: On `tSel` 111, the test pin toggles on every second rising edge of the ungated main output, including the /1 setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkVco | input | 1 | Oscillator clock; clocks all state |
| rstN | input | 1 | Asynchronous active-low reset |
| xtalClk | input | 1 | Crystal reference clock (oversampled) |
| extRefClk | input | 1 | External reference clock (oversampled) |
| refSel | input | 1 | 1 selects crystal, 0 selects external |
| serClk | input | 1 | Serial configuration clock (oversampled) |
| scanIn | input | 1 | Configuration shift-register output routed to test code 000 |
| mVal | input | M_W | Feedback divide value M |
| nCode | input | 2 | Output divide code |
| tSel | input | 3 | Test multiplexer select |
| outEn | input | 1 | Output enable |
| refClk | output | 1 | Prescaled reference to phase detector |
| fbClk | output | 1 | Feedback clock to phase detector |
| outClk | output | 1 | Main output, true side |
| outClkN | output | 1 | Main output, complement side |
| testOut | output | 1 | Test multiplexer output |

## Verification
The registered dividers (`fbClk`, the output divider and the /4 stage) change one `clkVco` edge after the count that triggers them. Prescaler and serial-divider toggles come one edge after the edge detector fires. The detector fires two edges after the slow input rises, because of the synchronizer, and from then on follows the count. The test multiplexer and the enable gating are combinational. The /1 setting is a clock pass-through, so outputs are sampled twice per cycle: mid-high and mid-low. A behavioural bench model advances once per rising edge and has the same edge latency as the design. Every output is compared in both half cycles after reset, and the reset state is checked on its own before release.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  // Strobes from control to datapath, one clkVco cycle wide.
  typedef struct packed {
    logic refTgl;    // prescaler half period done
    logic fbTgl;     // feedback M count wrapped
    logic serTgl;    // serial M count wrapped
    logic outSet;    // start a high phase of the output divider
    logic outClr;    // start a low phase / park for pass-through
    logic outTick;   // a rising edge of the main output happens now
    logic passThru;  // level: /1 setting active
  } divStrobes_t;

  localparam logic [1:0] N_PASS = 2'b11;

  // Half-period length of the output divider, in clkVco cycles.
  function automatic logic [2:0] halfLen(input logic [1:0] code);
    case (code)
      2'b00:   halfLen = 3'd1;
      2'b01:   halfLen = 3'd2;
      2'b10:   halfLen = 3'd4;
      default: halfLen = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/synth_div_sync.sv
module synth_div_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= d;
      end
      assign q = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
  import synth_div_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int REF_DIV     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clkVco,
  input  logic           rstN,
  input  logic           xtalClk,
  input  logic           extRefClk,
  input  logic           refSel,
  input  logic           serClk,
  input  logic [M_W-1:0] mVal,
  input  logic [1:0]     nCode,
  input  logic           outLevel,
  output divStrobes_t    stb
);
  localparam int REF_HALF = REF_DIV / 2;
  localparam int RC_W     = (REF_HALF > 1) ? $clog2(REF_HALF) : 1;
  localparam logic [RC_W-1:0] REF_LAST = RC_W'(REF_HALF - 1);

  // Slow clocks sampled into the oscillator domain.
  logic xtalS, extS, serS;
  synth_div_sync #(.STAGES(SYNC_STAGES)) u_syncXtal (.clk(clkVco), .rstN(rstN), .d(xtalClk),   .q(xtalS));
  synth_div_sync #(.STAGES(SYNC_STAGES)) u_syncExt  (.clk(clkVco), .rstN(rstN), .d(extRefClk), .q(extS));
  synth_div_sync #(.STAGES(SYNC_STAGES)) u_syncSer  (.clk(clkVco), .rstN(rstN), .d(serClk),    .q(serS));

  logic refLvl, refPrev, serPrev, refEdge, serEdge;
  assign refLvl  = refSel ? xtalS : extS;
  assign refEdge = refLvl & ~refPrev;
  assign serEdge = serS & ~serPrev;

  always_ff @(posedge clkVco or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      serPrev <= 1'b0;
    end else begin
      refPrev <= refLvl;
      serPrev <= serS;
    end
  end

  // Reference prescaler: half of REF_DIV edges per toggle.
  logic [RC_W-1:0] refCnt;
  logic            refWrap;
  assign refWrap = refEdge && (refCnt == REF_LAST);

  always_ff @(posedge clkVco or negedge rstN) begin
    if (!rstN)        refCnt <= '0;
    else if (refWrap) refCnt <= '0;
    else if (refEdge) refCnt <= refCnt + RC_W'(1);
  end

  // Feedback M counter; M is reloaded only on wrap.
  logic [M_W-1:0] fbCnt, fbM;
  logic [M_W:0]   fbNext;
  logic           fbWrap;
  assign fbNext = {1'b0, fbCnt} + (M_W+1)'(1);
  assign fbWrap = fbNext >= {1'b0, fbM};

  always_ff @(posedge clkVco or negedge rstN) begin
    if (!rstN) begin
      fbCnt <= '0;
      fbM   <= '0;
    end else if (fbWrap) begin
      fbCnt <= '0;
      fbM   <= mVal;
    end else begin
      fbCnt <= fbNext[M_W-1:0];
    end
  end

  // Serial M counter, advanced by serial clock edges.
  logic [M_W-1:0] serCnt, serM;
  logic [M_W:0]   serNext;
  logic           serWrap;
  assign serNext = {1'b0, serCnt} + (M_W+1)'(1);
  assign serWrap = serEdge && (serNext >= {1'b0, serM});

  always_ff @(posedge clkVco or negedge rstN) begin
    if (!rstN) begin
      serCnt <= '0;
      serM   <= '0;
    end else if (serWrap) begin
      serCnt <= '0;
      serM   <= mVal;
    end else if (serEdge) begin
      serCnt <= serNext[M_W-1:0];
    end
  end

  // Output divider sequencing; code swaps only at end of a low phase.
  logic [1:0] nAct;
  logic [2:0] hCnt;
  logic       passNow, lastHalf, boundary, fallNow;
  assign passNow  = (nAct == N_PASS);
  assign lastHalf = (hCnt + 3'd1) == halfLen(nAct);
  assign boundary = passNow || (!outLevel && lastHalf);
  assign fallNow  = !passNow && outLevel && lastHalf;

  always_ff @(posedge clkVco or negedge rstN) begin
    if (!rstN) begin
      nAct <= 2'b00;
      hCnt <= '0;
    end else if (boundary) begin
      nAct <= nCode;
      hCnt <= '0;
    end else if (fallNow) begin
      hCnt <= '0;
    end else begin
      hCnt <= hCnt + 3'd1;
    end
  end

  always_comb begin
    stb.refTgl   = refWrap;
    stb.fbTgl    = fbWrap;
    stb.serTgl   = serWrap;
    stb.outSet   = boundary && (nCode != N_PASS);
    stb.outClr   = (boundary && (nCode == N_PASS)) || fallNow;
    stb.outTick  = boundary;
    stb.passThru = passNow;
  end
endmodule

// File: rtl/synth_div_path.sv
module synth_div_path
  import synth_div_pkg::*;
(
  input  logic        clkVco,
  input  logic        rstN,
  input  divStrobes_t stb,
  input  logic        scanIn,
  input  logic [2:0]  tSel,
  input  logic        outEn,
  output logic        refClk,
  output logic        fbClk,
  output logic        outClk,
  output logic        outClkN,
  output logic        testOut,
  output logic        outLevel
);
  logic refHalf, fbHalf, serHalf, outReg;
  logic [1:0] qCnt;

  always_ff @(posedge clkVco or negedge rstN) begin
    if (!rstN) begin
      refHalf <= 1'b0;
      fbHalf  <= 1'b0;
      serHalf <= 1'b0;
      outReg  <= 1'b0;
      qCnt    <= 2'b00;
    end else begin
      if (stb.refTgl)  refHalf <= ~refHalf;
      if (stb.fbTgl)   fbHalf  <= ~fbHalf;
      if (stb.serTgl)  serHalf <= ~serHalf;
      if (stb.outSet)      outReg <= 1'b1;
      else if (stb.outClr) outReg <= 1'b0;
      if (stb.outTick) qCnt <= qCnt + 2'd1;
    end
  end

  // /1 setting: the oscillator clock itself, parked low register otherwise.
  logic outPre;
  assign outPre = stb.passThru ? clkVco : outReg;

  assign outClk   = outEn & outPre;
  assign outClkN  = ~outClk;
  assign refClk   = refHalf;
  assign fbClk    = fbHalf;
  assign outLevel = outReg;

  always_comb begin
    case (tSel)
      3'd0:    testOut = scanIn;
      3'd1:    testOut = 1'b1;
      3'd2:    testOut = refHalf;
      3'd3:    testOut = fbHalf;
      3'd4:    testOut = outPre;
      3'd5:    testOut = 1'b0;
      3'd6:    testOut = serHalf;
      default: testOut = qCnt[1];
    endcase
  end
endmodule

// File: rtl/synth_div_top.sv
module synth_div_top
  import synth_div_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int REF_DIV     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clkVco,
  input  logic           rstN,
  input  logic           xtalClk,
  input  logic           extRefClk,
  input  logic           refSel,
  input  logic           serClk,
  input  logic           scanIn,
  input  logic [M_W-1:0] mVal,
  input  logic [1:0]     nCode,
  input  logic [2:0]     tSel,
  input  logic           outEn,
  output logic           refClk,
  output logic           fbClk,
  output logic           outClk,
  output logic           outClkN,
  output logic           testOut
);
  divStrobes_t stb;
  logic        outLevel;

  synth_div_ctrl #(.M_W(M_W), .REF_DIV(REF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkVco(clkVco), .rstN(rstN), .xtalClk(xtalClk), .extRefClk(extRefClk),
    .refSel(refSel), .serClk(serClk), .mVal(mVal), .nCode(nCode),
    .outLevel(outLevel), .stb(stb)
  );

  synth_div_path u_path (
    .clkVco(clkVco), .rstN(rstN), .stb(stb), .scanIn(scanIn), .tSel(tSel),
    .outEn(outEn), .refClk(refClk), .fbClk(fbClk), .outClk(outClk),
    .outClkN(outClkN), .testOut(testOut), .outLevel(outLevel)
  );
endmodule

// File: rtl/synth_div_chk.sv
module synth_div_chk (
  input logic       clkVco,
  input logic       rstN,
  input logic       outEn,
  input logic [2:0] tSel,
  input logic       scanIn,
  input logic       testOut,
  input logic       outClk,
  input logic       outClkN,
  input logic       refClk,
  input logic       fbClk,
  input logic       refTgl,
  input logic       fbTgl
);
  p_oe_park_r8: assert property (@(posedge clkVco) disable iff (!rstN)
    !outEn |-> (!outClk && outClkN));

  p_test_high_r7: assert property (@(posedge clkVco) disable iff (!rstN)
    (tSel == 3'd1) |-> testOut);

  p_test_low_r7: assert property (@(posedge clkVco) disable iff (!rstN)
    (tSel == 3'd5) |-> !testOut);

  p_test_scan_r7: assert property (@(posedge clkVco) disable iff (!rstN)
    (tSel == 3'd0) |-> (testOut == scanIn));

  // R2: prescaled reference moves only after a prescaler wrap strobe
  p_ref_step_r2: assert property (@(posedge clkVco) disable iff (!rstN)
    (refClk != $past(refClk)) |-> $past(refTgl));

  // R3: feedback clock moves only after an M count wrap
  p_fb_step_r3: assert property (@(posedge clkVco) disable iff (!rstN)
    (fbClk != $past(fbClk)) |-> $past(fbTgl));
endmodule

bind synth_div_top synth_div_chk u_chk (
  .clkVco(clkVco), .rstN(rstN), .outEn(outEn), .tSel(tSel), .scanIn(scanIn),
  .testOut(testOut), .outClk(outClk), .outClkN(outClkN), .refClk(refClk),
  .fbClk(fbClk), .refTgl(stb.refTgl), .fbTgl(stb.fbTgl)
);

// File: tb/synth_div_top_tb.sv
module synth_div_top_tb;
  localparam int M_W = 9;

  logic clkVco = 1'b0;
  logic rstN = 1'b0;
  logic xtalClk = 1'b0, extRefClk = 1'b0, refSel = 1'b1, serClk = 1'b0, scanIn = 1'b0;
  logic [M_W-1:0] mVal = 9'd5;
  logic [1:0] nCode = 2'b00;
  logic [2:0] tSel = 3'd2;
  logic outEn = 1'b1;
  logic refClk, fbClk, outClk, outClkN, testOut;

  always #10 clkVco = ~clkVco;

  synth_div_top #(.M_W(M_W)) u_dut (
    .clkVco(clkVco), .rstN(rstN), .xtalClk(xtalClk), .extRefClk(extRefClk),
    .refSel(refSel), .serClk(serClk), .scanIn(scanIn), .mVal(mVal), .nCode(nCode),
    .tSel(tSel), .outEn(outEn), .refClk(refClk), .fbClk(fbClk), .outClk(outClk),
    .outClkN(outClkN), .testOut(testOut)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit serRun = 0, done = 0;
  string phaseReq = "R1";

  // Behavioural model state
  bit x1, x2, e1, e2, s1, s2, refPrevM, serPrevM;
  int refEdges, fbCount, fbLoad, serEdges, serLoad, halfCount, qCount;
  bit refT, fbT, serT, outHi;
  int nCur;

  function automatic int halfOf(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    x1 = 0; x2 = 0; e1 = 0; e2 = 0; s1 = 0; s2 = 0; refPrevM = 0; serPrevM = 0;
    refEdges = 0; fbCount = 0; fbLoad = 0; serEdges = 0; serLoad = 0;
    halfCount = 0; qCount = 0; refT = 0; fbT = 0; serT = 0; outHi = 0; nCur = 0;
  endtask

  task automatic modelStep();
    bit lvl, rEdge, sEdge;
    int h;
    lvl = refSel ? x2 : e2;
    rEdge = lvl && !refPrevM;
    sEdge = s2 && !serPrevM;
    refPrevM = lvl; serPrevM = s2;
    x2 = x1; x1 = xtalClk; e2 = e1; e1 = extRefClk; s2 = s1; s1 = serClk;
    if (rEdge) begin
      refEdges++;
      if (refEdges == 8) begin refEdges = 0; refT = !refT; end
    end
    // R3/R4: count with the loaded M, reload at wrap only
    if (fbCount + 1 >= fbLoad) begin fbCount = 0; fbT = !fbT; fbLoad = int'(mVal); end
    else fbCount++;
    if (sEdge) begin
      if (serEdges + 1 >= serLoad) begin serEdges = 0; serT = !serT; serLoad = int'(mVal); end
      else serEdges++;
    end
    // R5/R6: new code only when a low phase ends
    h = halfOf(nCur);
    if (nCur == 3 || (!outHi && halfCount + 1 == h)) begin
      nCur = int'(nCode); halfCount = 0; outHi = (nCode != 2'b11); qCount++;
    end else if (outHi && halfCount + 1 == h) begin
      halfCount = 0; outHi = 0;
    end else halfCount++;
  endtask

  task automatic check(input string sig, input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s act=%0b exp=%0b at cycle %0d", req, phaseReq, sig, act, exp, cyc);
    end
  endtask

  task automatic compareAll(input bit highPhase);
    bit pre, expOut, expTest;
    string tReq;
    pre = (nCur == 3) ? highPhase : outHi;
    expOut = outEn && pre;
    case (tSel)
      3'd0: begin expTest = scanIn; tReq = "R7"; end
      3'd1: begin expTest = 1'b1;   tReq = "R7"; end
      3'd2: begin expTest = refT;   tReq = "R2"; end
      3'd3: begin expTest = fbT;    tReq = "R3"; end
      3'd4: begin expTest = pre;    tReq = "R7"; end
      3'd5: begin expTest = 1'b0;   tReq = "R7"; end
      3'd6: begin expTest = serT;   tReq = "R9"; end
      default: begin expTest = qCount[1]; tReq = "R10"; end
    endcase
    check("refClk",  "R2", refClk, refT);
    check("fbClk",   "R3", fbClk, fbT);
    check("outClk",  outEn ? "R5" : "R8", outClk, expOut);
    check("outClkN", "R8", outClkN, !expOut);
    check("testOut", tReq, testOut, expTest);
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      xtalClk   = ((cyc / 3) % 2) == 1;
      extRefClk = ((cyc / 5) % 2) == 1;
      serClk    = serRun && (((cyc / 2) % 2) == 1);
      if (tSel == 3'd0) scanIn = ((cyc / 7) % 2) == 1;
      @(posedge clkVco);
      modelStep();
      cyc++;
      #5 compareAll(1'b1);
      @(negedge clkVco);
      #5 compareAll(1'b0);
    end
  endtask

  initial begin
    modelReset();
    repeat (4) @(negedge clkVco);
    #5;
    // R1: reset state
    phaseReq = "R1";
    check("refClk",  "R1", refClk, 1'b0);
    check("fbClk",   "R1", fbClk, 1'b0);
    check("outClk",  "R1", outClk, 1'b0);
    check("outClkN", "R1", outClkN, 1'b1);
    check("testOut", "R1", testOut, 1'b0);
    rstN = 1'b1;
    phaseReq = "R2"; runCycles(220);
    phaseReq = "R3"; tSel = 3'd3; runCycles(100);
    phaseReq = "R4"; mVal = 9'd3; runCycles(60);       // R4 reload at wrap
    phaseReq = "R3"; mVal = 9'd0; runCycles(20);       // M of 0 as 1
    phaseReq = "R6"; mVal = 9'd4; nCode = 2'b01; runCycles(60);  // R6 change at low end
    phaseReq = "R5"; nCode = 2'b10; runCycles(80);
    phaseReq = "R5"; nCode = 2'b11; runCycles(40);
    phaseReq = "R7"; tSel = 3'd4; runCycles(40);
    phaseReq = "R10"; tSel = 3'd7; runCycles(40);
    phaseReq = "R6"; nCode = 2'b00; runCycles(30);
    phaseReq = "R10"; nCode = 2'b01; runCycles(60);
    phaseReq = "R2"; refSel = 1'b0; tSel = 3'd2; runCycles(330);
    phaseReq = "R9"; serRun = 1; tSel = 3'd6; mVal = 9'd3; runCycles(200);
    phaseReq = "R9"; mVal = 9'd5; runCycles(120);
    phaseReq = "R7"; tSel = 3'd0; runCycles(60);
    tSel = 3'd1; runCycles(10);
    tSel = 3'd5; runCycles(10);
    phaseReq = "R8"; outEn = 1'b0; runCycles(40);
    outEn = 1'b1; nCode = 2'b11; runCycles(20);
    outEn = 1'b0; runCycles(20);
    outEn = 1'b1; runCycles(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule